// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits on the slave side of a processor bus and answers the interrupt acknowledge read. It watches the master's transfer start strobe together with the direction, size and transfer type lines. When the cycle matches the configured acknowledge code, it puts an 8-bit vector number on the top byte of the 32-bit read data bus. In the same clock it pulls an input enable strobe and the transfer acknowledge low.

A local interrupt source offers a vector together with a valid flag. When no source has a vector, the responder returns the spurious vector 0x18 on the same byte lane, so the master completes the cycle normally. A 4-bit configuration input sets a number of wait states that hold off the acknowledge. The master treats every clock without acknowledge as a wait state and samples again on the next edge. The responder removes its strobes on the clock after the master accepts the data.

Top module: `irq_vec_responder`

## Requirements
- R1: After a synchronous reset, ack_n and ien_n are high (negated) and rdata is all zeros.
- R2: A response starts only on a rising edge where ts_n is low, rd is 1, size equals 2'b01 and ttype equals 2'b11. A write, or any other size or type code, leaves ack_n and ien_n high and rdata zero.
- R3: With wait_cfg = 0, ack_n and ien_n are low during the clock that follows the start edge, so they are valid at the edge that ends the second bus clock.
- R4: With wait_cfg = N (1 to 15, sampled at the start edge), ack_n and ien_n stay high for N clocks after the start edge and are low during clock N+1.
- R5: ien_n and ack_n always carry the same level.
- R6: While ack_n is low, rdata[31:24] holds the vector. rdata[23:0] is always zero, and all of rdata is zero while ack_n is high.
- R7: The vector is vec_in when vec_valid is 1 at the edge that asserts acknowledge, and 0x18 otherwise.
- R8: ack_n and ien_n are low for exactly one clock and return high on the edge at which the master samples them.
- R9: A transfer start seen while a response is pending or active is ignored and produces no extra acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ts_n | input | 1 | Transfer start from the master, active low |
| rd | input | 1 | Transfer direction, 1 = read |
| size | input | 2 | Transfer size code from the master |
| ttype | input | 2 | Transfer type code from the master |
| wait_cfg | input | 4 | Number of wait states inserted before acknowledge |
| vec_valid | input | 1 | Local source has a vector pending |
| vec_in | input | 8 | Vector number from the local source |
| rdata | output | 32 | Read data bus, vector on bits 31:24 |
| ien_n | output | 1 | Input enable strobe, active low |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The assertions assume the master holds the transfer start strobe low for a single clock per cycle. They also assume it starts no new bus cycle until the acknowledge it is waiting for has been returned. The spurious-vector check assumes vec_valid and vec_in change only between clock edges. The stimulus drives every input on the falling edge and raises the start strobe again after one clock. It keeps the vector inputs steady through each response. The one case where it starts a second cycle too early is a deliberate probe of the ignore rule, and the assertions stay true during it.

// File: rtl/iackr_pkg.sv
package iackr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } resp_state_e;
endpackage

// File: rtl/iackr_decode.sv
module iackr_decode #(
  parameter int SZ_W = 2,
  parameter int TT_W = 2,
  parameter logic [SZ_W-1:0] IACK_SIZE = 2'b01,
  parameter logic [TT_W-1:0] IACK_TT   = 2'b11
) (
  input  logic            ts_n,
  input  logic            rd,
  input  logic [SZ_W-1:0] size,
  input  logic [TT_W-1:0] ttype,
  output logic            hit
);
  always_comb begin
    hit = !ts_n && rd && (size == IACK_SIZE) && (ttype == IACK_TT);
  end
endmodule

// File: rtl/iackr_wait_timer.sv
module iackr_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  input  logic [WAIT_W-1:0] init,
  output logic              last
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  always_comb begin
    last = (cnt_q == WAIT_W'(1));
  end
endmodule

// File: rtl/iackr_vec_drive.sv
module iackr_vec_drive #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_in,
  output logic [DATA_W-1:0] rdata,
  output logic              ien_n,
  output logic              ack_n
);
  localparam int LOW_W = DATA_W - VEC_W;

  logic [VEC_W-1:0] pick;

  always_comb begin
    pick = vec_valid ? vec_in : SPUR_VEC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ien_n <= 1'b1;
      ack_n <= 1'b1;
    end else if (fire) begin
      rdata <= {pick, {LOW_W{1'b0}}};
      ien_n <= 1'b0;
      ack_n <= 1'b0;
    end else begin
      rdata <= '0;
      ien_n <= 1'b1;
      ack_n <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder
  import iackr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int WAIT_W = 4,
  parameter int SZ_W   = 2,
  parameter int TT_W   = 2,
  parameter logic [SZ_W-1:0]  IACK_SIZE = 2'b01,
  parameter logic [TT_W-1:0]  IACK_TT   = 2'b11,
  parameter logic [VEC_W-1:0] SPUR_VEC  = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_n,
  input  logic              rd,
  input  logic [SZ_W-1:0]   size,
  input  logic [TT_W-1:0]   ttype,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_in,
  output logic [DATA_W-1:0] rdata,
  output logic              ien_n,
  output logic              ack_n
);
  resp_state_e state_q, state_d;
  logic start_hit;
  logic busy;
  logic tmr_load, tmr_dec, tmr_last;
  logic fire;

  iackr_decode #(
    .SZ_W(SZ_W), .TT_W(TT_W), .IACK_SIZE(IACK_SIZE), .IACK_TT(IACK_TT)
  ) u_decode (
    .ts_n(ts_n), .rd(rd), .size(size), .ttype(ttype), .hit(start_hit)
  );

  iackr_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .dec(tmr_dec),
    .init(wait_cfg), .last(tmr_last)
  );

  iackr_vec_drive #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)
  ) u_drive (
    .clk(clk), .rst(rst), .fire(fire), .vec_valid(vec_valid),
    .vec_in(vec_in), .rdata(rdata), .ien_n(ien_n), .ack_n(ack_n)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    fire     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_hit) begin
          if (wait_cfg == '0) begin
            fire    = 1'b1;
            state_d = ST_ACK;
          end else begin
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        tmr_dec = 1'b1;
        if (tmr_last) begin
          fire    = 1'b1;
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    busy = (state_q != ST_IDLE);
  end
endmodule

// File: rtl/iackr_checker.sv
module iackr_checker #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int WAIT_W = 4,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              start_hit,
  input logic              busy,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_in,
  input logic [DATA_W-1:0] rdata,
  input logic              ien_n,
  input logic              ack_n
);
  localparam int LOW_W = DATA_W - VEC_W;

  // R5
  strobes_paired_chk: assert property (@(posedge clk) disable iff (rst)
    ien_n == ack_n);

  // R6
  low_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[LOW_W-1:0] == '0);

  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ack_n |-> rdata == '0);

  // R8
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> ack_n);

  // R3
  zero_wait_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (start_hit && !busy && wait_cfg == '0) |=> !ack_n);

  // R7
  vector_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !$past(rst)) |->
      rdata[DATA_W-1:LOW_W] == ($past(vec_valid) ? $past(vec_in) : SPUR_VEC));
endmodule

bind irq_vec_responder iackr_checker #(
  .DATA_W(DATA_W), .VEC_W(VEC_W), .WAIT_W(WAIT_W), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .start_hit(start_hit), .busy(busy),
  .wait_cfg(wait_cfg), .vec_valid(vec_valid), .vec_in(vec_in),
  .rdata(rdata), .ien_n(ien_n), .ack_n(ack_n)
);

// File: tb/irq_vec_responder_test.sv
`timescale 1ns/1ps
module irq_vec_responder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ts_n;
  logic        rd;
  logic [1:0]  size;
  logic [1:0]  ttype;
  logic [3:0]  wait_cfg;
  logic        vec_valid;
  logic [7:0]  vec_in;
  logic [31:0] rdata;
  logic        ien_n;
  logic        ack_n;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_vec_responder uut (
    .clk(clk), .rst(rst), .ts_n(ts_n), .rd(rd), .size(size), .ttype(ttype),
    .wait_cfg(wait_cfg), .vec_valid(vec_valid), .vec_in(vec_in),
    .rdata(rdata), .ien_n(ien_n), .ack_n(ack_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(ack_n == 1'b1, req, {31'd0, ack_n}, 32'd1);
    check(ien_n == 1'b1, req, {31'd0, ien_n}, 32'd1);
    check(rdata == 32'd0, req, rdata, 32'd0);
  endtask

  task automatic start_pulse(input logic r, input logic [1:0] sz, input logic [1:0] tt);
    ts_n = 1'b0; rd = r; size = sz; ttype = tt;
    @(negedge clk);
    ts_n = 1'b1;
  endtask

  // R3 R4 R6 R7 R8: one acknowledge cycle with n wait states
  task automatic run_iack(input int n, input logic vv, input logic [7:0] v);
    logic [7:0] exp_v;
    exp_v = vv ? v : 8'h18;
    vec_valid = vv; vec_in = v; wait_cfg = 4'(n);
    start_pulse(1'b1, 2'b01, 2'b11);
    for (int j = 0; j < n; j++) begin
      check(ack_n && ien_n, "R4 held off", {30'd0, ack_n, ien_n}, 32'd3);
      @(negedge clk);
    end
    check(!ack_n, n == 0 ? "R3 ack" : "R4 ack", {31'd0, ack_n}, 32'd0);
    check(!ien_n, "R5 ien with ack", {31'd0, ien_n}, 32'd0);
    check(rdata == {exp_v, 24'd0}, vv ? "R6 vector" : "R7 spurious",
          rdata, {exp_v, 24'd0});
    @(negedge clk);
    check_idle("R8 negate after accept");
  endtask

  // R2: non-matching cycles leave the outputs idle
  task automatic run_nomatch(input logic r, input logic [1:0] sz, input logic [1:0] tt);
    wait_cfg = 4'd0; vec_valid = 1'b1; vec_in = 8'hA5;
    start_pulse(r, sz, tt);
    for (int j = 0; j < 4; j++) begin
      check_idle("R2 ignored cycle");
      @(negedge clk);
    end
  endtask

  // R9: a second start during the wait is ignored
  task automatic run_overlap();
    int acks = 0;
    wait_cfg = 4'd5; vec_valid = 1'b1; vec_in = 8'h3C;
    start_pulse(1'b1, 2'b01, 2'b11);
    @(negedge clk);
    wait_cfg = 4'd0;
    start_pulse(1'b1, 2'b01, 2'b11);
    for (int j = 0; j < 3; j++) begin
      check(ack_n, "R9 no early ack", {31'd0, ack_n}, 32'd1);
      @(negedge clk);
    end
    check(!ack_n && rdata == 32'h3C00_0000, "R9 original ack", rdata, 32'h3C00_0000);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (!ack_n) acks++;
    end
    check(acks == 0, "R9 single ack", 32'(acks), 32'd0);
  endtask

  initial begin
    rst = 1'b1; ts_n = 1'b1; rd = 1'b0; size = 2'b00; ttype = 2'b00;
    wait_cfg = 4'd0; vec_valid = 1'b0; vec_in = 8'd0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    run_iack(0, 1'b1, 8'h40);
    run_iack(0, 1'b0, 8'hFF);
    for (int n = 1; n <= 15; n++) begin
      run_iack(n, n[0], 8'(8'h50 + n));
      @(negedge clk);
    end
    run_nomatch(1'b0, 2'b01, 2'b11);
    run_nomatch(1'b1, 2'b10, 2'b11);
    run_nomatch(1'b1, 2'b01, 2'b00);
    run_overlap();
    run_iack(2, 1'b1, 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule